// File: doc/BRIEF.md
# Unit-Partitioned Multiport Register File

This block is the operand store of a wide-instruction processor core. It holds sixteen 32-bit registers split into four banks of four, one bank per functional unit: branch/call, load/store, ALU A and ALU B. Every unit can read any of the sixteen registers. Each unit writes only its own bank, and within it names a register with a short 2-bit index. Because every bank has exactly one writer, all four units can retire a result in the same cycle without any arbitration or conflict logic.

Eight read ports feed the two sources of each ALU, the base and store-data operands of the load/store unit, and the test and target operands of the branch unit. Read data follows the read address with no clock in between. Writes take effect on the rising clock edge. A read of a register in the same cycle as a write to it returns the old contents. Decoding of instructions and the data memory are outside this block.

The block has no control sequencer. Its behaviour is a single clocked update of each bank, plus purely combinational read selection. No state machine states or transitions exist to enumerate.

Top module: `urf_top`

## Requirements
- R1: While `rst_n` is low, all sixteen registers are cleared to zero, and a read of any register after reset returns zero.
- R2: A read address is 4 bits. Bits [3:2] pick the unit bank (00 branch/call, 01 load/store, 10 ALU A, 11 ALU B). Bits [1:0] pick the register inside that bank. Write port k always writes bank k, whose code is the binary value of k.
- R3: When `wr_en[k]` is high at a rising clock edge, register `wr_idx[k]` of bank k takes `wr_data[k]`. Any read port addressing it returns the new value from the following cycle on.
- R4: When `wr_en[k]` is low, bank k keeps all four values, whatever `wr_idx[k]` and `wr_data[k]` carry.
- R5: All four write ports may be enabled in the same cycle, and each lands its own value in its own bank.
- R6: A read in the same cycle as a write to the addressed register returns the value held before that write.
- R7: Each of the eight read ports independently and combinationally returns the register named by its own address. Several ports may name the same register.
- R8: A write to one register leaves the other three registers of the same bank, and every register of the other banks, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears every register |
| wr_en | input | 4 | Write enable per bank, bit k for bank k |
| wr_idx | input | 4x2 | Register index within bank k for write port k |
| wr_data | input | 4x32 | Write data for port k |
| rd_addr | input | 8x4 | Read address per port, {unit, index} |
| rd_data | output | 8x32 | Read data per port, combinational |

## Verification
Read data is due in the same cycle as the address, so the bench drives addresses on the falling edge and samples one nanosecond later, well before the next rising edge. A write shows up one rising edge after its enable is sampled. The bench therefore checks the pre-write value in the cycle that carries the write, and the new value after the following falling edge. It updates its own model of the sixteen registers only at that rising edge. Sweeps cover every index with all four banks writing at once, disabled writes with live data, single-bank writes, and every port reading every register.

// File: rtl/urf_pkg.sv
package urf_pkg;
    localparam int UNITS       = 4;
    localparam int REGS_PER    = 4;
    localparam int WORD_W      = 32;
    localparam int READ_PORTS  = 8;
    localparam int UNIT_BITS   = $clog2(UNITS);
    localparam int IDX_BITS    = $clog2(REGS_PER);
    localparam int ADDR_BITS   = UNIT_BITS + IDX_BITS;

    typedef enum logic [1:0] {
        UNIT_BRANCH = 2'b00,
        UNIT_LDST   = 2'b01,
        UNIT_ALU_A  = 2'b10,
        UNIT_ALU_B  = 2'b11
    } unit_e;
endpackage

// File: rtl/urf_bank.sv
module urf_bank #(
    parameter int WORD_W   = 32,
    parameter int REGS_PER = 4,
    localparam int IDX_BITS = $clog2(REGS_PER)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_BITS-1:0]               wr_idx,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic [REGS_PER-1:0][WORD_W-1:0]   regs_q
);

    for (genvar j = 0; j < REGS_PER; j++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[j] <= '0;
            end else if (wr_en && (wr_idx == IDX_BITS'(j))) begin
                regs_q[j] <= wr_data;
            end
        end

        // R8: registers not addressed by the write keep their value
        a_r8_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en || wr_idx != IDX_BITS'(j)) |=> $stable(regs_q[j]));
    end

    // R1: reset holds the bank at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> regs_q == '0);

    // R3: an enabled write lands in the indexed register
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));

    // R4: a disabled port leaves the whole bank alone
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/urf_read_port.sv
module urf_read_port #(
    parameter int WORD_W   = 32,
    parameter int UNITS    = 4,
    parameter int REGS_PER = 4,
    localparam int UNIT_BITS = $clog2(UNITS),
    localparam int IDX_BITS  = $clog2(REGS_PER)
) (
    input  logic [UNITS-1:0][REGS_PER-1:0][WORD_W-1:0] file_q,
    input  logic [UNIT_BITS+IDX_BITS-1:0]              addr,
    output logic [WORD_W-1:0]                          data
);

    logic [UNIT_BITS-1:0]             unit_sel;
    logic [IDX_BITS-1:0]              idx_sel;
    logic [REGS_PER-1:0][WORD_W-1:0]  bank_sel;

    assign unit_sel = addr[UNIT_BITS+IDX_BITS-1:IDX_BITS];
    assign idx_sel  = addr[IDX_BITS-1:0];

    always_comb begin
        bank_sel = file_q[unit_sel];
        data     = bank_sel[idx_sel];
    end

endmodule

// File: rtl/urf_top.sv
module urf_top
    import urf_pkg::*;
#(
    parameter int DATA_W  = WORD_W,
    parameter int NUM_RD  = READ_PORTS,
    localparam int NUNIT  = UNITS,
    localparam int NREG   = REGS_PER,
    localparam int UBITS  = $clog2(NUNIT),
    localparam int IBITS  = $clog2(NREG),
    localparam int ABITS  = UBITS + IBITS
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUNIT-1:0]                   wr_en,
    input  logic [NUNIT-1:0][IBITS-1:0]        wr_idx,
    input  logic [NUNIT-1:0][DATA_W-1:0]       wr_data,
    input  logic [NUM_RD-1:0][ABITS-1:0]       rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0]      rd_data
);

    logic [NUNIT-1:0][NREG-1:0][DATA_W-1:0] file_q;

    for (genvar k = 0; k < NUNIT; k++) begin : g_bank
        urf_bank #(
            .WORD_W   (DATA_W),
            .REGS_PER (NREG)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[k]),
            .wr_idx  (wr_idx[k]),
            .wr_data (wr_data[k]),
            .regs_q  (file_q[k])
        );
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        urf_read_port #(
            .WORD_W   (DATA_W),
            .UNITS    (NUNIT),
            .REGS_PER (NREG)
        ) port_i (
            .file_q (file_q),
            .addr   (rd_addr[p]),
            .data   (rd_data[p])
        );

        for (genvar k = 0; k < NUNIT; k++) begin : g_chk
            // R3: port p sees the value written by bank k one edge later
            a_r3_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(wr_en[k]) &&
                 rd_addr[p] == {UBITS'(k), $past(wr_idx[k])})
                |-> rd_data[p] == $past(wr_data[k]));
        end
    end

endmodule

// File: tb/urf_top_tb_top.sv
module urf_top_tb_top;
    localparam int DW = 32;
    localparam int NU = 4;
    localparam int NR = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NU-1:0]          wr_en = '0;
    logic [NU-1:0][1:0]     wr_idx = '0;
    logic [NU-1:0][DW-1:0]  wr_data = '0;
    logic [NR-1:0][3:0]     rd_addr = '0;
    logic [NR-1:0][DW-1:0]  rd_data;

    logic [DW-1:0] model [16];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    urf_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check_ports(input string tag);
        for (int p = 0; p < NR; p++) begin
            checks++;
            if (rd_data[p] !== model[rd_addr[p]]) begin
                errors++;
                $display("FAIL %s port %0d addr %0d: got %h expected %h",
                         tag, p, rd_addr[p], rd_data[p], model[rd_addr[p]]);
            end
        end
    endtask

    // read all sixteen registers through the eight ports, two rounds
    task automatic read_all(input string tag);
        for (int round = 0; round < 2; round++) begin
            @(negedge clk);
            wr_en = '0;
            for (int p = 0; p < NR; p++) rd_addr[p] = 4'(round * 8 + p);
            #1 check_ports(tag);
        end
    endtask

    // one write cycle; ports 0..3 and 4..7 watch the addressed registers
    task automatic write_cycle(input logic [NU-1:0] en,
                               input logic [NU-1:0][1:0] idx,
                               input logic [NU-1:0][DW-1:0] dat);
        @(negedge clk);
        wr_en = en; wr_idx = idx; wr_data = dat;
        for (int k = 0; k < NU; k++) begin
            rd_addr[k]     = {2'(k), idx[k]};
            rd_addr[k + 4] = {2'(k), idx[k]};
        end
        #1 check_ports("R6 old value during write");
        @(posedge clk);
        for (int k = 0; k < NU; k++)
            if (en[k]) model[k * 4 + idx[k]] = dat[k];
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NU-1:0][1:0]    idx;
        logic [NU-1:0][DW-1:0] dat;
        for (int i = 0; i < 16; i++) model[i] = '0;
        // preload junk on write inputs while in reset: must not land (R1)
        wr_en = '1; wr_data = {NU{32'hDEAD_BEEF}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_en = '0;
        rst_n = 1'b1;
        read_all("R1 reset clears");

        // R5/R2/R3: all banks write together, every index
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < NU; k++) begin
                idx[k] = 2'(r);
                dat[k] = 32'h1000_0000 * (k + 1) + 32'h0000_0101 * (r + 3);
            end
            write_cycle(4'hF, idx, dat);
            read_all("R5 R2 R3 parallel write");
        end

        // R4: disabled ports with live data change nothing
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < NU; k++) begin
                idx[k] = 2'(r);
                dat[k] = 32'hFFFF_0000 ^ 32'(r * 17 + k);
            end
            write_cycle(4'h0, idx, dat);
            read_all("R4 disabled write");
        end

        // R8/R3: one bank, one register at a time; R6 on overwrite
        for (int k = 0; k < NU; k++) begin
            for (int r = 0; r < 4; r++) begin
                idx = '0; dat = '0;
                idx[k] = 2'(r);
                dat[k] = 32'hA5A5_0000 + 32'(k * 16 + r);
                write_cycle(4'(1 << k), idx, dat);
                read_all("R8 single write isolation");
            end
        end

        // R7: every port reads every register, distinct address per port
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            for (int p = 0; p < NR; p++) rd_addr[p] = 4'((i + p * 3) % 16);
            #1 check_ports("R7 independent ports");
        end
        // R7: all ports on one register
        @(negedge clk);
        for (int p = 0; p < NR; p++) rd_addr[p] = 4'd9;
        #1 check_ports("R7 shared address");

        // R1: reset again after data is present
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        read_all("R1 reset after use");

        finish_run();
    end
endmodule